// File: doc/BRIEF.md
# E3 Transmit Payload Entry Port

This block is the point where terminal equipment hands payload to an outbound E3 transmitter. A frame is 1536 bit periods long. The first 12 bit periods carry overhead: a 10-bit alignment word, an alarm bit and a national bit. The other 1524 bit periods carry payload. The block keeps one bit-position counter for the frame. It takes payload either one bit at a time or four bits at a time, and turns it into a single serial stream. Beside that stream runs a marker that flags which bit periods are overhead. The overhead content itself is inserted further down the transmit path.

The block also tells the terminal equipment what is coming. A warning strobe goes high in the bit period before each overhead bit. An end-of-frame strobe goes high on the final bit of a frame. In four-bit entry the block produces a nibble clock at one quarter of the bit rate, and this clock stops during overhead. Alignment can be handed to the terminal equipment: when enabled, a rising edge on a frame-reference input makes the next bit period bit 0 of a new frame.

Bit timing comes from either the local transmit clock or, in loop timing, the receive line clock. In loop timing the receive line clock is also passed out to the terminal equipment so that it can time its data.

Top module: `e3tx_payload_in`

## Requirements
- R1: While `rst_n` is low, and until the second rising edge of the bit clock after `rst_n` goes high, `oh_warn`, `eof`, `nib_clk`, `pay_out` and `pay_oh` are all low. The first bit period after that is frame bit 0, so the first `eof` is seen 1537 bit periods after release.
- R2: When `nib_mode` is 0 (serial entry), `ser_in` is sampled at the bit-clock edge that ends a payload bit period, and it appears on `pay_out` for the following bit period. `nib_in` has no effect in this mode.
- R3: When `nib_mode` is 1 (nibble entry), `nib_in` is sampled at the bit-clock edge that ends the first bit period of each 4-bit payload group. Group phase is counted as (bit position − 12) mod 4. Over the next four bit periods the sampled nibble appears on `pay_out` from bit 3 down to bit 0. `ser_in` has no effect in this mode.
- R4: `nib_clk` is high only in nibble entry, and only during payload bit periods whose group phase is 1 or 2. It is therefore low throughout overhead and always low in serial entry. Its rising edge marks the sampling edge of R3.
- R5: `oh_warn` is high in a bit period exactly when the next bit period is an overhead bit, that is, when the next bit position is 0 to 11. A frame-reference restart counts: it makes the next position 0.
- R6: For overhead bit positions 0 to 11, `pay_oh` is 1 and `pay_out` is 0 during the following bit period, whatever the data inputs carry. For payload positions `pay_oh` is 0.
- R7: `eof` is high for exactly one bit period, while bit position 1535 is being handled. The frame then wraps to position 0.
- R8: When `frm_ref_en` is 1, a 0-to-1 change of `frm_ref`, sampled at bit-clock edges, makes the next bit period position 0. The frame it cuts short gets no `eof`, and the restarted frame is again 1536 bit periods long. A level held high gives no further restart. When `frm_ref_en` is 0, `frm_ref` has no effect.
- R9: When `loop_sel` is 1, `rx_line_clk` is the bit clock and `te_clk_out` follows `rx_line_clk`. When `loop_sel` is 0, `tx_clk` is the bit clock and `te_clk_out` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Local transmit bit clock |
| rx_line_clk | input | 1 | Receive line clock, used as the bit clock in loop timing |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| loop_sel | input | 1 | Static select: 1 = loop timing, 0 = local clock |
| nib_mode | input | 1 | Static select: 1 = nibble entry, 0 = serial entry |
| frm_ref_en | input | 1 | Enables frame alignment from `frm_ref` |
| frm_ref | input | 1 | Frame reference; a rising edge restarts the frame |
| ser_in | input | 1 | Serial payload data from the terminal equipment |
| nib_in | input | 4 | Nibble payload data, bit 3 sent first |
| te_clk_out | output | 1 | Loop-timed clock passed to the terminal equipment |
| nib_clk | output | 1 | Nibble clock at a quarter of the bit rate, stopped during overhead |
| oh_warn | output | 1 | High when the next bit period is overhead |
| eof | output | 1 | High while the last bit of the frame is handled |
| pay_out | output | 1 | Merged serial payload stream, one bit period behind entry |
| pay_oh | output | 1 | High when the `pay_out` bit period is an overhead slot |

## Verification
The end-of-frame strobe, the overhead warning and a frame-reference restart can all fall on bit position 1535. The bench drives a rising edge of `frm_ref` into exactly that bit period and expects `eof` and `oh_warn` to be high together. It then expects the following frame to be a full 1536 bit periods. A second collision is a restart in the middle of a frame. Here the warning has to go high in the same bit period as the edge, and the end-of-frame strobe must not appear until 1536 bit periods after the restart; the bench counts those periods directly.

// File: rtl/e3tx_pkg.sv
// Shared constants and types for the E3 transmit payload entry port.
package e3tx_pkg;

  // Default frame geometry: overhead occupies the leading bit positions.
  parameter int unsigned FRAME_BITS_DEF = 1536;
  parameter int unsigned OH_BITS_DEF    = 12;
  parameter int unsigned NIB_W_DEF      = 4;

  // Entry path chosen by the static mode pin.
  typedef enum logic {
    ENTRY_SERIAL = 1'b0,
    ENTRY_NIBBLE = 1'b1
  } entry_e;

endpackage

// File: rtl/e3tx_rst_sync.sv
// Asynchronous assert, synchronous release of the active-low reset.
module e3tx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_ok
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  // Shift a constant one through the chain once reset is released.
  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_ok = sync_q[STAGES-1];

endmodule

// File: rtl/e3tx_frame_ctr.sv
// Frame bit-position counter with restart on a frame-reference edge,
// plus the overhead warning and end-of-frame strobes.
module e3tx_frame_ctr #(
  parameter int unsigned FRAME_BITS = 1536,
  parameter int unsigned OH_BITS    = 12,
  parameter int unsigned CNT_W      = 11
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             rst_ok,
  input  logic             ref_en,
  input  logic             frm_ref,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             oh_warn,
  output logic             eof
);

  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] OH_LIM   = CNT_W'(OH_BITS);

  logic cnt_q_en;
  logic ref_q;
  logic ref_d;
  logic frm_edge;
  logic at_last;

  assign at_last  = (cnt == LAST_POS);
  assign frm_edge = rst_ok & ref_en & frm_ref & ~ref_q;
  assign cnt_q_en = rst_ok;

  // Next bit position: a reference edge wins over normal wrap/increment.
  always_comb begin
    if (frm_edge) begin
      cnt_nxt = '0;
    end else if (at_last) begin
      cnt_nxt = '0;
    end else begin
      cnt_nxt = cnt + 1'b1;
    end
    ref_d = rst_ok ? frm_ref : 1'b0;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt   <= '0;
      ref_q <= 1'b0;
    end else begin
      if (cnt_q_en) begin
        cnt <= cnt_nxt;
      end
      ref_q <= ref_d;
    end
  end

  // Strobes are decoded from the current and next bit position.
  assign oh_warn = rst_ok & (cnt_nxt < OH_LIM);
  assign eof     = rst_ok & at_last;

  a_r7_eof_one_period: assert property (@(posedge clk) disable iff (!rst_ok)
    eof |=> !eof);

  a_r7_eof_wraps: assert property (@(posedge clk) disable iff (!rst_ok)
    eof |=> (cnt == '0));

  a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_ok)
    frm_edge |=> (cnt == '0));

endmodule

// File: rtl/e3tx_nib_clkgen.sv
// Nibble clock: a registered quarter-rate clock, stopped during overhead.
module e3tx_nib_clkgen #(
  parameter int unsigned OH_BITS = 12,
  parameter int unsigned NIB_W   = 4,
  parameter int unsigned CNT_W   = 11
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             rst_ok,
  input  logic             nib_mode,
  input  logic [CNT_W-1:0] cnt_nxt,
  output logic             nib_clk
);

  import e3tx_pkg::*;

  localparam int unsigned      NIB_LG = $clog2(NIB_W);
  localparam logic [CNT_W-1:0] OH_LIM = CNT_W'(OH_BITS);
  localparam logic [NIB_LG:0]  HALF   = (NIB_LG+1)'(NIB_W / 2);

  entry_e            mode_e;
  logic [NIB_LG-1:0] ph_nxt;
  logic              in_pay;
  logic              nclk_d;

  assign mode_e = entry_e'(nib_mode);
  assign ph_nxt = NIB_LG'(cnt_nxt - OH_LIM);
  assign in_pay = (cnt_nxt >= OH_LIM);

  // High for group phases 1..NIB_W/2 of the upcoming bit period.
  always_comb begin
    nclk_d = 1'b0;
    if (rst_ok && (mode_e == ENTRY_NIBBLE) && in_pay) begin
      nclk_d = (ph_nxt != '0) && ({1'b0, ph_nxt} <= HALF);
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      nib_clk <= 1'b0;
    end else begin
      nib_clk <= nclk_d;
    end
  end

  a_r4_serial_no_nclk: assert property (@(posedge clk) disable iff (!rst_ok)
    !nib_mode |-> !nib_clk);

endmodule

// File: rtl/e3tx_payload_sel.sv
// Payload capture and merge: serial bit or nibble shifted out MSB first,
// blanked with an overhead marker for overhead positions.
module e3tx_payload_sel #(
  parameter int unsigned OH_BITS = 12,
  parameter int unsigned NIB_W   = 4,
  parameter int unsigned CNT_W   = 11
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             rst_ok,
  input  logic             nib_mode,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ser_in,
  input  logic [NIB_W-1:0] nib_in,
  output logic             pay_out,
  output logic             pay_oh
);

  import e3tx_pkg::*;

  localparam int unsigned      NIB_LG = $clog2(NIB_W);
  localparam int unsigned      SH_W   = NIB_W - 1;
  localparam logic [CNT_W-1:0] OH_LIM = CNT_W'(OH_BITS);

  entry_e            mode_e;
  logic [NIB_LG-1:0] ph;
  logic              is_oh;
  logic [SH_W-1:0]   sh_q;
  logic [SH_W-1:0]   sh_d;
  logic              out_d;
  logic              oh_d;

  assign mode_e = entry_e'(nib_mode);
  assign is_oh  = (cnt < OH_LIM);
  assign ph     = NIB_LG'(cnt - OH_LIM);

  always_comb begin
    out_d = 1'b0;
    oh_d  = 1'b0;
    sh_d  = sh_q;
    if (!rst_ok) begin
      sh_d = '0;
    end else if (is_oh) begin
      oh_d = 1'b1;
    end else begin
      unique case (mode_e)
        ENTRY_NIBBLE: begin
          if (ph == '0) begin
            // Group start: send MSB now, keep the rest for later periods.
            out_d = nib_in[NIB_W-1];
            sh_d  = nib_in[SH_W-1:0];
          end else begin
            out_d = sh_q[SH_W-1];
            sh_d  = {sh_q[SH_W-2:0], 1'b0};
          end
        end
        default: begin
          out_d = ser_in;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pay_out <= 1'b0;
      pay_oh  <= 1'b0;
      sh_q    <= '0;
    end else begin
      pay_out <= out_d;
      pay_oh  <= oh_d;
      sh_q    <= sh_d;
    end
  end

  a_r6_oh_blank: assert property (@(posedge clk) disable iff (!rst_ok)
    pay_oh |-> !pay_out);

endmodule

// File: rtl/e3tx_payload_in.sv
// E3 transmit payload entry port: top level.
module e3tx_payload_in
  import e3tx_pkg::*;
#(
  parameter int unsigned FRAME_BITS = FRAME_BITS_DEF,
  parameter int unsigned OH_BITS    = OH_BITS_DEF,
  parameter int unsigned NIB_W      = NIB_W_DEF
) (
  input  logic             tx_clk,
  input  logic             rx_line_clk,
  input  logic             rst_n,
  input  logic             loop_sel,
  input  logic             nib_mode,
  input  logic             frm_ref_en,
  input  logic             frm_ref,
  input  logic             ser_in,
  input  logic [NIB_W-1:0] nib_in,
  output logic             te_clk_out,
  output logic             nib_clk,
  output logic             oh_warn,
  output logic             eof,
  output logic             pay_out,
  output logic             pay_oh
);

  localparam int unsigned CNT_W = $clog2(FRAME_BITS);

  logic             bit_clk;
  logic             rst_ok;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;

  // Timing reference: loop timing takes the receive line clock.
  assign bit_clk    = loop_sel ? rx_line_clk : tx_clk;
  assign te_clk_out = loop_sel & rx_line_clk;

  e3tx_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (bit_clk),
    .arst_n (rst_n),
    .rst_ok (rst_ok)
  );

  e3tx_frame_ctr #(
    .FRAME_BITS (FRAME_BITS),
    .OH_BITS    (OH_BITS),
    .CNT_W      (CNT_W)
  ) u_frame_ctr (
    .clk     (bit_clk),
    .arst_n  (rst_n),
    .rst_ok  (rst_ok),
    .ref_en  (frm_ref_en),
    .frm_ref (frm_ref),
    .cnt     (cnt),
    .cnt_nxt (cnt_nxt),
    .oh_warn (oh_warn),
    .eof     (eof)
  );

  e3tx_nib_clkgen #(
    .OH_BITS (OH_BITS),
    .NIB_W   (NIB_W),
    .CNT_W   (CNT_W)
  ) u_nib_clkgen (
    .clk      (bit_clk),
    .arst_n   (rst_n),
    .rst_ok   (rst_ok),
    .nib_mode (nib_mode),
    .cnt_nxt  (cnt_nxt),
    .nib_clk  (nib_clk)
  );

  e3tx_payload_sel #(
    .OH_BITS (OH_BITS),
    .NIB_W   (NIB_W),
    .CNT_W   (CNT_W)
  ) u_payload_sel (
    .clk      (bit_clk),
    .arst_n   (rst_n),
    .rst_ok   (rst_ok),
    .nib_mode (nib_mode),
    .cnt      (cnt),
    .ser_in   (ser_in),
    .nib_in   (nib_in),
    .pay_out  (pay_out),
    .pay_oh   (pay_oh)
  );

  // The warning leads the overhead marker by the entry pipeline plus one.
  a_r5_warn_leads_oh: assert property (@(posedge bit_clk) disable iff (!rst_ok)
    oh_warn |=> ##1 pay_oh);

  // Nibble clock only runs while payload is flowing out.
  a_r4_nclk_in_payload: assert property (@(posedge bit_clk) disable iff (!rst_ok)
    nib_clk |-> !pay_oh);

  // During the synchronous release window the registered outputs stay low.
  a_r1_quiet_in_sync: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !rst_ok |-> (!pay_oh && !nib_clk));

endmodule

// File: tb/e3tx_payload_in_bench.sv
module e3tx_payload_in_bench;

  localparam int FB = 1536;
  localparam int OH = 12;
  localparam int NW = 4;

  logic tx_clk = 1'b0;
  logic rx_line_clk = 1'b0;
  logic rst_n, loop_sel, nib_mode, frm_ref_en, frm_ref, ser_in;
  logic [NW-1:0] nib_in;
  logic te_clk_out, nib_clk, oh_warn, eof, pay_out, pay_oh;

  e3tx_payload_in u_e3tx_payload_in (
    .tx_clk(tx_clk), .rx_line_clk(rx_line_clk), .rst_n(rst_n),
    .loop_sel(loop_sel), .nib_mode(nib_mode), .frm_ref_en(frm_ref_en),
    .frm_ref(frm_ref), .ser_in(ser_in), .nib_in(nib_in),
    .te_clk_out(te_clk_out), .nib_clk(nib_clk), .oh_warn(oh_warn),
    .eof(eof), .pay_out(pay_out), .pay_oh(pay_oh)
  );

  // 100 MHz local clock; receive clock same rate, shifted by 3 ns.
  always #5 tx_clk = ~tx_clk;
  initial begin
    #3;
    forever #5 rx_line_clk = ~rx_line_clk;
  end

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // Behavioural reference state
  int       m_cnt;
  bit       m_act;
  int       m_sync;
  bit       m_prev;
  bit       e_out, e_oh, e_nclk;
  bit [3:0] m_nib;
  int       nib_fix = -1;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int next_pos();
    bit edge_seen;
    edge_seen = frm_ref_en && frm_ref && !m_prev;
    if (edge_seen) return 0;
    if (m_cnt == FB - 1) return 0;
    return m_cnt + 1;
  endfunction

  task automatic model_zero();
    m_act = 0; m_sync = 0; m_cnt = 0; m_prev = 0;
    e_out = 0; e_oh = 0; e_nclk = 0; m_nib = '0;
  endtask

  // One bit-clock edge of the reference, using the inputs held before it.
  task automatic model_step();
    int n, ph;
    if (!rst_n) begin
      model_zero();
    end else if (!m_act) begin
      m_sync++;
      if (m_sync >= 2) begin
        m_act = 1; m_cnt = 0; m_prev = 0;
      end
      e_out = 0; e_oh = 0; e_nclk = 0;
    end else begin
      n = next_pos();
      if (m_cnt < OH) begin
        e_out = 0; e_oh = 1;
      end else if (nib_mode) begin
        ph = (m_cnt - OH) % NW;
        if (ph == 0) begin
          m_nib = nib_in;
          e_out = nib_in[3];
        end else begin
          e_out = m_nib[3 - ph];
        end
        e_oh = 0;
      end else begin
        e_out = ser_in; e_oh = 0;
      end
      e_nclk = nib_mode && (n >= OH) && (((n - OH) % NW) == 1 || ((n - OH) % NW) == 2);
      m_prev = frm_ref;
      m_cnt = n;
    end
  endtask

  task automatic compare();
    string dtag;
    bit w_e, f_e;
    w_e = m_act && (next_pos() < OH);
    f_e = m_act && (m_cnt == FB - 1);
    if (!m_act) begin
      chk("R1 oh_warn", oh_warn, 1'b0);
      chk("R1 eof", eof, 1'b0);
      chk("R1 nib_clk", nib_clk, 1'b0);
      chk("R1 pay_out", pay_out, 1'b0);
      chk("R1 pay_oh", pay_oh, 1'b0);
    end else begin
      chk("R5 oh_warn", oh_warn, w_e);
      chk("R7 eof", eof, f_e);
      chk("R4 nib_clk", nib_clk, e_nclk);
      chk("R6 pay_oh", pay_oh, e_oh);
      dtag = e_oh ? "R6 pay_out" : (nib_mode ? "R3 pay_out" : "R2 pay_out");
      chk(dtag, pay_out, e_out);
    end
  endtask

  task automatic cycle(input logic ref_v);
    if (loop_sel) @(posedge rx_line_clk);
    else          @(posedge tx_clk);
    #1;
    chk("R9 te_clk_out", te_clk_out, loop_sel & rx_line_clk);
    model_step();
    ser_in = 1'($urandom);
    nib_in = (nib_fix >= 0) ? 4'(nib_fix) : 4'($urandom);
    frm_ref = ref_v;
    #5;
    compare();
  endtask

  task automatic do_reset(input logic lp, input logic nm);
    if (loop_sel) @(posedge rx_line_clk);
    else          @(posedge tx_clk);
    #1;
    rst_n = 1'b0;
    model_zero();
    loop_sel = lp;
    nib_mode = nm;
    frm_ref = 1'b0;
    for (int i = 0; i < 4; i++) cycle(1'b0);
    if (loop_sel) @(posedge rx_line_clk);
    else          @(posedge tx_clk);
    #1;
    model_step();
    rst_n = 1'b1;
    #5;
    compare();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int k;
    rst_n = 1'b0; loop_sel = 1'b0; nib_mode = 1'b0;
    frm_ref_en = 1'b0; frm_ref = 1'b0; ser_in = 1'b0; nib_in = '0;
    model_zero();

    // R1: reset, then first eof exactly 1537 bit periods after release.
    do_reset(1'b0, 1'b0);
    k = 0;
    do begin cycle(1'b0); k++; end while (eof !== 1'b1 && k < 2000);
    chk("R1 first eof distance", k == 1537, 1'b1);

    // R2/R5/R6/R7 serial entry; R8 edges ignored while disabled.
    for (int i = 0; i < FB + 200; i++) cycle((i % 700) inside {[500:502]});

    // R8: restart in the middle of a frame, the next eof comes 1536 later.
    frm_ref_en = 1'b1;
    while (m_cnt != 700) cycle(1'b0);
    cycle(1'b1);
    chk("R8 warn on restart edge", oh_warn, 1'b1);
    k = 0;
    do begin cycle(k < 5); k++; end while (eof !== 1'b1 && k < 2000);
    chk("R8 shortened frame no eof", k == 1536, 1'b1);

    // R7/R5/R8: restart edge on the last bit position.
    while (m_cnt != FB - 2) cycle(1'b0);
    cycle(1'b1);
    chk("R7 eof on coincident restart", eof, 1'b1);
    chk("R5 warn on coincident restart", oh_warn, 1'b1);
    k = 0;
    do begin cycle(1'b0); k++; end while (eof !== 1'b1 && k < 2000);
    chk("R8 full frame after coincident restart", k == FB, 1'b1);

    // R8: restart inside the overhead field.
    while (m_cnt != 5) cycle(1'b0);
    cycle(1'b1);
    for (int i = 0; i < 40; i++) cycle(1'b0);
    frm_ref_en = 1'b0;

    // R3/R4: nibble entry with a known nibble, sent MSB first.
    do_reset(1'b0, 1'b1);
    while (m_cnt != OH + 4 * 10 - 1) cycle(1'b0);
    nib_fix = 4'hA;
    cycle(1'b0);
    nib_fix = -1;
    cycle(1'b0); chk("R3 nibble bit3", pay_out, 1'b1);
    cycle(1'b0); chk("R3 nibble bit2", pay_out, 1'b0);
    cycle(1'b0); chk("R3 nibble bit1", pay_out, 1'b1);
    cycle(1'b0); chk("R3 nibble bit0", pay_out, 1'b0);
    for (int i = 0; i < FB + 100; i++) cycle(1'b0);

    // R9: loop timing with nibble and serial entry.
    do_reset(1'b1, 1'b0);
    for (int i = 0; i < FB + 100; i++) cycle(1'b0);
    do_reset(1'b1, 1'b1);
    for (int i = 0; i < 300; i++) cycle(1'b0);

    finish_run();
  end

endmodule